// File: doc/BRIEF.md
# Comparator Timer Slice

One timer slice of an event-timer block. It keeps a 64-bit configuration and capability word, a 32-bit match value (the comparator) and a 32-bit period. While the global counter enable is high, the slice compares the shared free-running main counter against the match value. When the two are equal, it produces a single-cycle fire pulse. In one-shot mode the match value stays where software put it. In periodic mode, each match moves the match value forward by one period, so the slice fires at a steady rate.

The register block in front of the slice issues masked 64-bit writes and selects which register appears on the read port. Two behaviours set periodic mode apart:

- A comparator write always replaces the period. It replaces the next match value only when software has first armed a value-set bit in the configuration, and every comparator write disarms that bit again.
- Capability bits are read-only. No configuration write can change them.

Routing the fire pulse to an interrupt line or to a message is left to a neighbouring block.

Top module: `tmr_slice`

## Requirements
- R1: After reset the configuration reads 0x0000_0000_0000_8010, the comparator reads 0x0000_0000_FFFF_FFFF and fire is 0.
- R2: A configuration write (new = old & ~mask | data & mask) never changes the read-only fields. These are bits 63:32 (allowed-route map, reset 0), bit 15 (message-capable, reset 1), bit 5 (counter-size, reset 0) and bit 4 (periodic-capable, reset 1).
- R3: After any configuration write, bit 8 (force-32-bit) reads 0. All other bits take the masked write value.
- R4: With configuration bit 3 (periodic) at 0, a comparator write merges bits 31:0 of data under bits 31:0 of mask into the match value, and the period becomes 0.
- R5: With bit 3 at 1, a comparator write merges the data into the period. It also copies the new period into the match value only if bit 6 (value-set) was 1.
- R6: After every comparator write, configuration bit 6 reads 0.
- R7: A configuration write that leaves bit 3 at 0 forces the stored period to 0.
- R8: When cnt_en is 1 and the main counter equals the match value in a cycle, fire is 1 for exactly the following cycle. This holds even if the equality persists.
- R9: While cnt_en is 0, fire stays 0 whatever the counter value.
- R10: In periodic mode with a non-zero period, a match advances the match value by one period, modulo 2^32, at the same edge that raises fire.
- R11: In periodic mode with a period of 0, a match leaves the match value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_en | input | 1 | Global main-counter enable |
| main_cnt | input | 32 | Shared main counter value |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 configuration, 1 comparator |
| wr_data | input | 64 | Write data |
| wr_mask | input | 64 | Per-bit write mask |
| rd_sel | input | 1 | Read source: 0 configuration, 1 comparator (zero-extended) |
| rd_data | output | 64 | Selected register contents |
| fire | output | 1 | One-cycle match pulse |

## Verification
A write takes effect at the clock edge that samples the strobe. Because the read port is combinational, the result is visible right after that edge. The bench drives every write on a falling edge and reads back on the next falling edge.

A counter value that equals the match value raises fire one rising edge later, and a periodic advance lands on that same edge. The bench therefore sets the counter on a falling edge and checks fire and the new match value on the next falling edge. It checks for fire low on the falling edge after that.

Random masked writes with the counter disabled are compared against a bench model of the configuration, match value and period.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_W = 64;

  // configuration bit positions decoded by neighbouring blocks
  localparam int B_IRQ_EN   = 2;
  localparam int B_PERIODIC = 3;
  localparam int B_PER_CAP  = 4;
  localparam int B_SIZE     = 5;
  localparam int B_VALSET   = 6;
  localparam int B_FORCE32  = 8;
  localparam int B_MSG_CAP  = 15;
  localparam int ROUTE_LSB  = 32;

  localparam logic [REG_W-1:0] CFG_RO_MASK =
    (64'hFFFF_FFFF << ROUTE_LSB) | (64'd1 << B_MSG_CAP) |
    (64'd1 << B_SIZE) | (64'd1 << B_PER_CAP);

  localparam logic [REG_W-1:0] CFG_CAP_RST =
    (64'd1 << B_MSG_CAP) | (64'd1 << B_PER_CAP);

  typedef enum logic {SEL_CFG = 1'b0, SEL_CMP = 1'b1} reg_sel_e;

  function automatic logic [REG_W-1:0] merge64(
      input logic [REG_W-1:0] old_v,
      input logic [REG_W-1:0] new_v,
      input logic [REG_W-1:0] mask);
    merge64 = (old_v & ~mask) | (new_v & mask);
  endfunction
endpackage

// File: rtl/tmr_cfg_reg.sv
module tmr_cfg_reg
  import tmr_pkg::*;
#(
  parameter logic [REG_W-1:0] RST_VAL = CFG_CAP_RST
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cfg,
  input  logic [REG_W-1:0] wr_data,
  input  logic [REG_W-1:0] wr_mask,
  input  logic             clr_valset,
  output logic [REG_W-1:0] cfg_q,
  output logic             per_clear
);
  logic [REG_W-1:0] cfg_d;
  logic [REG_W-1:0] merged;
  logic             cfg_en;

  localparam logic [REG_W-1:0] FORCE_MASK = 64'd1 << B_FORCE32;

  always_comb begin
    merged = merge64(cfg_q, wr_data, wr_mask);
    cfg_d  = cfg_q;
    if (wr_cfg)
      cfg_d = (merged & ~CFG_RO_MASK & ~FORCE_MASK) | (cfg_q & CFG_RO_MASK);
    if (clr_valset)
      cfg_d[B_VALSET] = 1'b0;
  end

  assign cfg_en    = wr_cfg | clr_valset;
  assign per_clear = wr_cfg & ~cfg_d[B_PERIODIC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= RST_VAL;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  // R2
  ro_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cfg |=> ((cfg_q & CFG_RO_MASK) == (RST_VAL & CFG_RO_MASK)));

  // R3
  force32_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cfg |=> !cfg_q[B_FORCE32]);

  // R6
  valset_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valset |=> !cfg_q[B_VALSET]);
endmodule

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] main_cnt,
  input  logic             wr_cmp,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [CNT_W-1:0] wr_mask,
  input  logic             periodic,
  input  logic             valset,
  input  logic             per_clear,
  output logic [CNT_W-1:0] cmp_q,
  output logic             hit
);
  logic [CNT_W-1:0] per_q, per_d, cmp_d, new_per;
  logic             advance, cmp_en, per_en;

  assign hit     = cnt_en && (main_cnt == cmp_q);
  assign advance = hit && periodic && (per_q != '0) && !wr_cmp;
  assign new_per = (per_q & ~wr_mask) | (wr_data & wr_mask);

  always_comb begin
    cmp_d = cmp_q;
    per_d = per_q;
    if (wr_cmp) begin
      if (periodic) begin
        per_d = new_per;
        if (valset) cmp_d = new_per;
      end else begin
        cmp_d = (cmp_q & ~wr_mask) | (wr_data & wr_mask);
        per_d = '0;
      end
    end else if (advance) begin
      cmp_d = cmp_q + per_q;
    end
    if (per_clear) per_d = '0;
  end

  assign cmp_en = wr_cmp | advance;
  assign per_en = wr_cmp | per_clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '1;
    else if (cmp_en) cmp_q <= cmp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      per_q <= '0;
    else if (per_en) per_q <= per_d;
  end

  // R10
  periodic_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && periodic && per_q != '0 && !wr_cmp) |=> cmp_q == $past(cmp_q) + $past(per_q));

  // R11
  zero_period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && per_q == '0 && !wr_cmp) |=> $stable(cmp_q));

  // R7
  oneshot_period_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !periodic |-> per_q == '0);
endmodule

// File: rtl/tmr_fire_gen.sv
module tmr_fire_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  output logic fire
);
  logic hit_q, fire_d;

  assign fire_d = hit & ~hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      fire  <= 1'b0;
    end else begin
      hit_q <= hit;
      fire  <= fire_d;
    end
  end

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
endmodule

// File: rtl/tmr_slice.sv
module tmr_slice
  import tmr_pkg::*;
#(
  parameter int          CNT_W          = 32,
  parameter logic [31:0] ALLOWED_ROUTES = 32'h0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] main_cnt,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic [REG_W-1:0] wr_mask,
  input  logic             rd_sel,
  output logic [REG_W-1:0] rd_data,
  output logic             fire
);
  localparam int PAD_W = REG_W - CNT_W;
  localparam logic [REG_W-1:0] CFG_RST =
    CFG_CAP_RST | ({32'h0, ALLOWED_ROUTES} << ROUTE_LSB);

  logic [1:0]       rst_sync;
  logic             rst_i_n;
  logic             wr_cfg, wr_cmp;
  logic [REG_W-1:0] cfg_q;
  logic [CNT_W-1:0] cmp_q;
  logic             per_clear, hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  assign wr_cfg = wr_en && (reg_sel_e'(wr_sel) == SEL_CFG);
  assign wr_cmp = wr_en && (reg_sel_e'(wr_sel) == SEL_CMP);

  tmr_cfg_reg #(.RST_VAL(CFG_RST)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .wr_cfg    (wr_cfg),
    .wr_data   (wr_data),
    .wr_mask   (wr_mask),
    .clr_valset(wr_cmp),
    .cfg_q     (cfg_q),
    .per_clear (per_clear)
  );

  tmr_cmp_unit #(.CNT_W(CNT_W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .cnt_en   (cnt_en),
    .main_cnt (main_cnt),
    .wr_cmp   (wr_cmp),
    .wr_data  (wr_data[CNT_W-1:0]),
    .wr_mask  (wr_mask[CNT_W-1:0]),
    .periodic (cfg_q[B_PERIODIC]),
    .valset   (cfg_q[B_VALSET]),
    .per_clear(per_clear),
    .cmp_q    (cmp_q),
    .hit      (hit)
  );

  tmr_fire_gen u_fire (
    .clk  (clk),
    .rst_n(rst_i_n),
    .hit  (hit),
    .fire (fire)
  );

  assign rd_data = (reg_sel_e'(rd_sel) == SEL_CMP) ? {{PAD_W{1'b0}}, cmp_q} : cfg_q;

  // R9
  fire_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    fire |-> $past(cnt_en));
endmodule

// File: tb/sim_tmr_slice.sv
module sim_tmr_slice;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnt_en;
  logic [31:0] main_cnt;
  logic        wr_en, wr_sel, rd_sel;
  logic [63:0] wr_data, wr_mask, rd_data;
  logic        fire;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [63:0] m_cfg;
  logic [31:0] m_cmp, m_per;

  localparam logic [63:0] RO = 64'hFFFF_FFFF_0000_8030;

  always #2.5 clk = ~clk;

  tmr_slice u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .main_cnt(main_cnt),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .wr_mask(wr_mask),
    .rd_sel(rd_sel), .rd_data(rd_data), .fire(fire)
  );

  function automatic logic [63:0] f_cfg(logic [63:0] o, logic [63:0] d, logic [63:0] m);
    logic [63:0] t;
    t = (o & ~m) | (d & m);
    t[8] = 1'b0;
    return (t & ~RO) | (o & RO);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [63:0] d, logic [63:0] m);
    wr_en = 1'b1; wr_sel = sel; wr_data = d; wr_mask = m;
    @(negedge clk);
    wr_en = 1'b0;
    if (!sel) begin
      m_cfg = f_cfg(m_cfg, d, m);
      if (!m_cfg[3]) m_per = 32'h0;
    end else begin
      if (m_cfg[3]) begin
        m_per = (m_per & ~m[31:0]) | (d[31:0] & m[31:0]);
        if (m_cfg[6]) m_cmp = m_per;
      end else begin
        m_cmp = (m_cmp & ~m[31:0]) | (d[31:0] & m[31:0]);
        m_per = 32'h0;
      end
      m_cfg[6] = 1'b0;
    end
  endtask

  task automatic rd_chk(string req);
    rd_sel = 1'b0; #0.5;
    chk(req, rd_data, m_cfg);
    rd_sel = 1'b1; #0.5;
    chk(req, rd_data, {32'h0, m_cmp});
  endtask

  // counter reaches value v: fire next cycle, then low; match value advances
  task automatic match_at(string req, logic [31:0] v, logic exp_fire);
    main_cnt = v;
    @(negedge clk);
    chk(req, {63'h0, fire}, {63'h0, exp_fire});
    if (exp_fire && m_cfg[3] && m_per != 0) m_cmp = m_cmp + m_per;
    rd_sel = 1'b1; #0.5;
    chk(req, rd_data, {32'h0, m_cmp});
    @(negedge clk);
    chk(req, {63'h0, fire}, 64'h0);
    main_cnt = m_cmp - 32'd7;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; cnt_en = 1'b0; main_cnt = 32'h0;
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0; wr_mask = '0; rd_sel = 1'b0;
    m_cfg = 64'h8010; m_cmp = 32'hFFFF_FFFF; m_per = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 fire", {63'h0, fire}, 64'h0);
    rd_sel = 1'b0; #0.5; chk("R1 cfg", rd_data, 64'h0000_0000_0000_8010);
    rd_sel = 1'b1; #0.5; chk("R1 cmp", rd_data, 64'h0000_0000_FFFF_FFFF);

    // R2 R3 all ones into configuration
    wr(1'b0, '1, '1);
    rd_sel = 1'b0; #0.5; chk("R2 R3 cfg ones", rd_data, 64'h0000_0000_FFFF_FEDF);
    wr(1'b0, 64'h0, '1);
    rd_sel = 1'b0; #0.5; chk("R2 cfg zero", rd_data, 64'h0000_0000_0000_8010);

    // R4 one-shot load, masked
    wr(1'b1, 64'hABCD_0000_0000_0064, '1);
    rd_chk("R4 oneshot load");
    wr(1'b1, 64'h0000_0000_1234_5678, 64'hFFFF_FFFF_0000_0000);
    rd_chk("R4 upper mask ignored");
    wr(1'b1, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_FF00);
    rd_chk("R4 partial mask");
    chk("R4 value", {32'h0, m_cmp}, 64'h64);

    // R9 disabled counter
    main_cnt = 32'h64;
    @(negedge clk); chk("R9 no fire", {63'h0, fire}, 64'h0);
    @(negedge clk); chk("R9 no fire", {63'h0, fire}, 64'h0);
    main_cnt = 32'h0;
    @(negedge clk);

    // R8 one-shot match, equality held
    cnt_en = 1'b1;
    main_cnt = 32'h63;
    @(negedge clk); chk("R8 before", {63'h0, fire}, 64'h0);
    main_cnt = 32'h64;
    @(negedge clk); chk("R8 pulse", {63'h0, fire}, 64'h1);
    @(negedge clk); chk("R8 single", {63'h0, fire}, 64'h0);
    @(negedge clk); chk("R8 single", {63'h0, fire}, 64'h0);
    rd_chk("R8 oneshot hold");
    main_cnt = 32'h0;
    cnt_en = 1'b0;
    @(negedge clk);

    // R5 R6 periodic with value-set
    wr(1'b0, 64'h48, 64'hFF);
    rd_chk("R5 arm");
    wr(1'b1, 64'd50, '1);
    rd_chk("R6 valset cleared");
    chk("R5 loaded", {32'h0, m_cmp}, 64'd50);
    cnt_en = 1'b1;
    match_at("R10 first", 32'd50, 1'b1);
    chk("R10 advanced", {32'h0, m_cmp}, 64'd100);
    match_at("R10 second", 32'd100, 1'b1);
    cnt_en = 1'b0;

    // R5 without value-set: period only
    wr(1'b1, 64'd30, '1);
    rd_chk("R5 no valset");
    chk("R5 cmp kept", {32'h0, m_cmp}, 64'd150);
    cnt_en = 1'b1;
    match_at("R10 new period", 32'd150, 1'b1);
    chk("R10 value", {32'h0, m_cmp}, 64'd180);
    cnt_en = 1'b0;

    // R10 wrap
    wr(1'b0, 64'h48, 64'hFF);
    wr(1'b1, 64'hFFFF_FFF0, '1);
    wr(1'b1, 64'h20, '1);
    rd_chk("R10 wrap setup");
    cnt_en = 1'b1;
    match_at("R10 wrap", 32'hFFFF_FFF0, 1'b1);
    chk("R10 wrap value", {32'h0, m_cmp}, 64'h10);
    cnt_en = 1'b0;

    // R7 R11 leaving periodic zeroes period; zero period holds match
    wr(1'b0, 64'h0, 64'hFF);
    wr(1'b0, 64'h08, 64'hFF);
    rd_chk("R7 cfg");
    cnt_en = 1'b1;
    match_at("R11 zero period", 32'h10, 1'b1);
    chk("R7 R11 held", {32'h0, m_cmp}, 64'h10);
    cnt_en = 1'b0;

    // random masked writes, counter disabled
    for (int i = 0; i < 300; i++) begin
      logic [63:0] d, m;
      d = {$urandom, $urandom};
      case ($urandom % 4)
        0: m = '1;
        1: m = 64'h0000_0000_FFFF_FFFF;
        2: m = 64'hFFFF_FFFF_0000_0000;
        default: m = {$urandom, $urandom};
      endcase
      wr(1'($urandom % 2), d, m);
      rd_chk("R2 R3 R4 R5 R6 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule